// File: doc/BRIEF.md
# Programmable down-count timer channel

This block is a single timer channel that counts down on a one-microsecond tick enable and raises a level interrupt when its count runs out. Software programs it with one control word holding a run bit, a repeat-mode bit and a terminal count. The count follows an n+1 rule: a loaded value of n expires on the (n+1)th tick, so a load of 0 expires on the very next tick. Valid intervals therefore run from 1 to 2^29 ticks.

In single-shot mode the run bit drops by itself when the count expires. In repeat mode the channel reloads its count and keeps going with no tick lost. A system tick uses repeat mode with a count of (tick rate / tick frequency) - 1. Each expiry sets a sticky pending flag. That flag drives the interrupt pin until software writes a one to the acknowledge bit of the status word.

The channel sits in an 8-byte window on a 32-bit register bus. The window's base address is a parameter, so several copies can be placed side by side by an outer decoder.

Top module: `dtimer_chan`

## Requirements
- R1: After reset the interrupt output is low and both the control word (offset 0) and the status word (offset 4) read as zero.
- R2: A control write with bit 31 set and count n in bits 28:0 makes the interrupt rise on the (n+1)th tick that follows the write; n = 0 expires on the first tick.
- R3: In single-shot mode (bit 30 clear) the expiry clears bit 31 of the control read-back and leaves bits 30 and 28:0 as written. Later ticks cause no further expiry.
- R4: In repeat mode (bit 30 set) the count reloads on expiry, and the channel expires again every n+1 ticks with no gap.
- R5: Writing all zeros to the control word stops the channel, so no later tick raises the interrupt.
- R6: A control write while the channel is running restarts the count from the new value. A tick in the same cycle as the write is not counted.
- R7: The pending flag, and with it the interrupt, stays high until a status write has bit 30 set. A status write with bit 30 clear has no effect.
- R8: When an acknowledge and a new expiry fall in the same cycle, the flag stays pending.
- R9: A status read returns the pending flag in bit 30 and the remaining count in bits 28:0. A control read returns the run bit, the mode bit and the loaded count.
- R10: Only the addresses BASE and BASE+4 respond. Writes elsewhere change nothing, and reads elsewhere return zero.
- R11: The count changes only in cycles where the tick enable is high and the channel is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle tick enable, nominally 1 MHz |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt, high while an expiry is pending |

## Verification
A behavioural model is compared with the interrupt and the read data on every cycle. The stimulus covers several patterns:
- Single-shot loads of 3 and 0 separate the n+1 rule from an off-by-one count.
- A repeat-mode load of 2, with an acknowledge after each expiry, shows the reload gives a period of exactly three ticks.
- Reloading mid-count with a tick in the same cycle, and acknowledging in the very cycle of a new expiry, show which action takes priority.
- Writes and reads outside the window, gaps with the tick enable low, and a placement at a non-zero base show that decoding and counting react only to what they should.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned RUN_BIT  = 31;
   localparam int unsigned MODE_BIT = 30;
   localparam int unsigned ACK_BIT  = 30;
   localparam int unsigned WIN_LSB  = 3;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2
   } dtimer_sel_e;
endpackage

// File: rtl/dtimer_decode.sv
module dtimer_decode
   import dtimer_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE_ADDR = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output dtimer_sel_e       sel,
   output logic              ctrl_wr,
   output logic              stat_wr
);
   localparam int unsigned TAG_W = ADDR_W - WIN_LSB;
   localparam logic [TAG_W-1:0] BASE_TAG = TAG_W'(BASE_ADDR >> WIN_LSB);

   generate
      if (ADDR_W <= WIN_LSB) begin : g_bad_addr_w
         $error("ADDR_W too small for an 8-byte window");
      end
      if ((BASE_ADDR % 8) != 0) begin : g_bad_align
         $error("BASE_ADDR must be 8-byte aligned");
      end
      if (ADDR_W < 32 && BASE_ADDR + 8 > (64'd1 << ADDR_W)) begin : g_bad_range
         $error("BASE_ADDR window does not fit in ADDR_W");
      end
   endgenerate

   logic hit;
   assign hit = (addr[ADDR_W-1:WIN_LSB] == BASE_TAG);

   always_comb begin
      sel = SEL_NONE;
      if (hit) begin
         case (addr[WIN_LSB-1:0])
            3'd0:    sel = SEL_CTRL;
            3'd4:    sel = SEL_STAT;
            default: sel = SEL_NONE;
         endcase
      end
   end

   assign ctrl_wr = wr && (sel == SEL_CTRL);
   assign stat_wr = wr && (sel == SEL_STAT);
endmodule

// File: rtl/dtimer_count.sv
module dtimer_count #(
   parameter int unsigned CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic             load_run,
   input  logic             load_rep,
   input  logic [CNT_W-1:0] load_val,
   output logic             run,
   output logic             rep,
   output logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] remain,
   output logic             expire
);
   generate
      if (CNT_W < 1 || CNT_W > 30) begin : g_bad_cnt_w
         $error("CNT_W must lie in 1..30 to stay below the mode bit");
      end
   endgenerate

   logic at_zero;
   assign at_zero = (remain == '0);
   assign expire  = run && tick && !load && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= 1'b0;
         rep    <= 1'b0;
         reload <= '0;
         remain <= '0;
      end else if (load) begin
         run    <= load_run;
         rep    <= load_rep;
         reload <= load_val;
         remain <= load_val;
      end else if (run && tick) begin
         if (at_zero) begin
            if (rep) remain <= reload;
            else     run    <= 1'b0;
         end else begin
            remain <= remain - 1'b1;
         end
      end
   end

   a_r2_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load && remain != '0) |=> (remain == $past(remain) - 1'b1));
   a_r3_single_shot_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !rep) |=> !run);
   a_r4_repeat_reloads: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && rep) |=> (run && remain == reload));
   a_r11_holds_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> ($stable(remain) && $stable(run)));
endmodule

// File: rtl/dtimer_flag.sv
module dtimer_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)   pend <= 1'b0;
      else if (set) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend);
   a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend);
   a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !pend);
endmodule

// File: rtl/dtimer_chan.sv
module dtimer_chan
   import dtimer_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE_ADDR = 0,
   parameter int unsigned CNT_W     = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   dtimer_sel_e      sel;
   logic             ctrl_wr, stat_wr, ack;
   logic             run, rep, expire;
   logic [CNT_W-1:0] reload, remain;
   logic             wdata_unused;

   assign wdata_unused = ^bus_wdata;

   dtimer_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
      .addr    (bus_addr),
      .wr      (bus_wr),
      .sel     (sel),
      .ctrl_wr (ctrl_wr),
      .stat_wr (stat_wr)
   );

   dtimer_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_en),
      .load     (ctrl_wr),
      .load_run (bus_wdata[RUN_BIT]),
      .load_rep (bus_wdata[MODE_BIT]),
      .load_val (bus_wdata[CNT_W-1:0]),
      .run      (run),
      .rep      (rep),
      .reload   (reload),
      .remain   (remain),
      .expire   (expire)
   );

   assign ack = stat_wr && bus_wdata[ACK_BIT];

   dtimer_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (expire),
      .clr   (ack),
      .pend  (irq)
   );

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_CTRL: begin
            bus_rdata[RUN_BIT]     = run;
            bus_rdata[MODE_BIT]    = rep;
            bus_rdata[CNT_W-1:0]   = reload;
         end
         SEL_STAT: begin
            bus_rdata[ACK_BIT]     = irq;
            bus_rdata[CNT_W-1:0]   = remain;
         end
         default: bus_rdata = '0;
      endcase
   end

   a_r5_zero_write_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata == 32'd0) |=> !run);
   a_r10_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE && !tick_en) |=> ($stable(run) && $stable(reload) && $stable(remain)));
   a_r6_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (remain == $past(bus_wdata[CNT_W-1:0])));
endmodule

// File: tb/dtimer_chan_tb.sv
module dtimer_chan_tb_top;
   localparam int unsigned ADDR_W = 12;
   localparam int unsigned BASE   = 12'h058;
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(BASE + 4);
   localparam logic [31:0] EN  = 32'h8000_0000;
   localparam logic [31:0] PER = 32'h4000_0000;
   localparam logic [31:0] ACK = 32'h4000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_en = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dtimer_chan #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .CNT_W(29)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // behavioural reference
   bit          m_run, m_per, m_irq;
   int unsigned m_n, m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_per = 0; m_irq = 0; m_n = 0; m_cnt = 0;
      end else begin
         bit cw, sw, fire;
         cw   = bus_wr && bus_addr == CTRL_A;
         sw   = bus_wr && bus_addr == STAT_A;
         fire = m_run && tick_en && !cw && m_cnt == 0;
         if (cw) begin
            m_run = bus_wdata[31]; m_per = bus_wdata[30];
            m_n = bus_wdata[28:0]; m_cnt = m_n;
         end else if (m_run && tick_en) begin
            if (m_cnt == 0) begin
               if (m_per) m_cnt = m_n; else m_run = 0;
            end else m_cnt = m_cnt - 1;
         end
         if (fire) m_irq = 1;
         else if (sw && bus_wdata[30]) m_irq = 0;
      end
   end

   function automatic logic [31:0] model_rd(logic [ADDR_W-1:0] a);
      logic [31:0] r = '0;
      if (a == CTRL_A) begin r[31] = m_run; r[30] = m_per; r[28:0] = m_n[28:0]; end
      else if (a == STAT_A) begin r[30] = m_irq; r[28:0] = m_cnt[28:0]; end
      return r;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   initial begin
      forever begin
         @(negedge clk); #3;
         if (cmp_on) begin
            chk(irq === m_irq, "R7 irq vs model", 32'(irq), 32'(m_irq));
            chk(bus_rdata === model_rd(bus_addr), "R9 rdata vs model", bus_rdata, model_rd(bus_addr));
         end
      end
   end

   task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d, bit tk);
      bus_wr = 1; bus_addr = a; bus_wdata = d; tick_en = tk;
      @(negedge clk);
      bus_wr = 0; tick_en = 0;
   endtask

   task automatic tick_n(int k);
      repeat (k) begin tick_en = 1; @(negedge clk); end
      tick_en = 0;
   endtask

   task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic finish_up();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         finish_up();
      end
   end

   initial begin
      logic [31:0] d;
      int got, nexp, first, last;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cmp_on = 1;
      // R1 reset state
      chk(irq == 0, "R1 irq after reset", 32'(irq), 0);
      rd(CTRL_A, d); chk(d == 0, "R1 ctrl after reset", d, 0);
      rd(STAT_A, d); chk(d == 0, "R1 stat after reset", d, 0);

      // R2 n+1 rule, n=3
      wr(CTRL_A, EN | 32'd3, 0);
      got = 0;
      for (int i = 1; i <= 8; i++) begin tick_n(1); if (irq && got == 0) got = i; end
      chk(got == 4, "R2 load 3 expires on tick 4", got, 4);
      // R3 single shot stopped, fields kept
      rd(CTRL_A, d); chk(d == 32'd3, "R3 run bit self-clears", d, 32'd3);
      // R7 write without ack bit ignored
      wr(STAT_A, 32'hBFFF_FFFF, 0);
      chk(irq == 1, "R7 no-ack write keeps pending", 32'(irq), 1);
      wr(STAT_A, ACK, 0);
      chk(irq == 0, "R7 ack clears", 32'(irq), 0);
      tick_n(5);
      chk(irq == 0, "R3 no re-fire after single shot", 32'(irq), 0);

      // R2 n=0 fires on first tick
      wr(CTRL_A, EN, 0);
      tick_n(1);
      chk(irq == 1, "R2 load 0 expires on first tick", 32'(irq), 1);
      wr(STAT_A, ACK, 0);

      // R4 repeat mode, n=2
      wr(CTRL_A, EN | PER | 32'd2, 0);
      nexp = 0; first = 0; last = 0;
      for (int i = 1; i <= 9; i++) begin
         tick_n(1);
         if (irq) begin
            nexp++; if (first == 0) first = i; last = i;
            wr(STAT_A, ACK, 0);
         end
      end
      chk(nexp == 3, "R4 expiry count", nexp, 3);
      chk(first == 3 && last == 9, "R4 period of three ticks", first * 100 + last, 309);

      // R5 zero write stops
      wr(CTRL_A, 32'd0, 0);
      tick_n(10);
      chk(irq == 0, "R5 stopped channel silent", 32'(irq), 0);
      rd(CTRL_A, d); chk(d == 0, "R5 ctrl reads zero", d, 0);

      // R6 restart mid-count, R9 remaining count
      wr(CTRL_A, EN | 32'd10, 0);
      tick_n(4);
      rd(STAT_A, d); chk(d == 32'd6, "R9 remaining count", d, 32'd6);
      wr(CTRL_A, EN | 32'd2, 1);
      rd(STAT_A, d); chk(d == 32'd2, "R6 restart ignores same-cycle tick", d, 32'd2);
      got = 0;
      for (int i = 1; i <= 5; i++) begin tick_n(1); if (irq && got == 0) got = i; end
      chk(got == 3, "R6 new count expires on tick 3", got, 3);
      wr(STAT_A, ACK, 0);

      // R8 ack and expiry same cycle
      wr(CTRL_A, EN | PER, 0);
      tick_n(1);
      wr(STAT_A, ACK, 1);
      chk(irq == 1, "R8 expiry beats ack", 32'(irq), 1);
      wr(STAT_A, ACK, 0);
      chk(irq == 0, "R7 ack after R8", 32'(irq), 0);
      wr(CTRL_A, 32'd0, 0);

      // R11 no tick, no count
      wr(CTRL_A, EN | 32'd1, 0);
      repeat (5) @(negedge clk);
      rd(STAT_A, d); chk(d == 32'd1, "R11 count holds without tick", d, 32'd1);
      chk(irq == 0, "R11 no expiry without tick", 32'(irq), 0);
      wr(CTRL_A, 32'd0, 0);

      // R10 stray addresses
      wr(ADDR_W'(BASE + 8), EN | 32'd1, 0);
      wr(ADDR_W'(BASE - 8), EN, 0);
      tick_n(4);
      chk(irq == 0, "R10 stray write no start", 32'(irq), 0);
      rd(CTRL_A, d); chk(d == 0, "R10 ctrl untouched", d, 0);
      wr(CTRL_A, EN | PER | 32'd7, 0);
      rd(ADDR_W'(BASE + 8), d); chk(d == 0, "R10 stray read zero", d, 0);
      rd(ADDR_W'(BASE + 2), d); chk(d == 0, "R10 odd offset read zero", d, 0);
      rd(CTRL_A, d); chk(d == (EN | PER | 32'd7), "R9 ctrl read-back", d, EN | PER | 32'd7);

      @(negedge clk);
      cmp_on = 0;
      done = 1;
      finish_up();
   end
endmodule